// File: doc/BRIEF.md
# Clock Output Gate and Mode Controller

This block decides, for every clock output of a multi-domain clock generator, whether the output toggles, is held low, or has its driver released to high impedance. It combines three control sources. A two-bit test-mode field can float most outputs. Four active-low power-management pins can stop groups of clocks or power everything down. A keep bit per output holds that output low when the bit is cleared. The block also chooses the three-bit frequency selection, taken either from strap pins or from a register field, and it produces the spread-spectrum enable.

Four of the memory-clock pins have two uses, chosen by a mode strap. With the strap at 1 they are ordinary memory clock outputs and the power-management pins are ignored. With the strap at 0 they carry the stop and power-down inputs, so their drivers stay released. Each clock group has a simple divided test clock. Each output's decision is applied only on that test clock's falling edge, so a gated output never shows a shortened high phase. The registered state is brought out together with a gated copy of the test clock for each output.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: Each output index has exactly one of `out_run`, `out_low`, `out_hiz` set. While reset is held, every output is high impedance, every test clock is low, `freq_sel` is 0 and `spread_en` is 0.
- R2: `cfg_tmode` = 2'b11 sets high impedance on every output except the two AGP outputs (indices 22 and 23). This overrides power-down, the stop pins and the keep bits. The AGP outputs keep following the other rules.
- R3: With `strap_mode` = 0 and `pm_pin_n[2]` = 0 (power-down), every output that is not high impedance is held low.
- R4: With `strap_mode` = 0 and `pm_pin_n[1]` = 0, the CPU outputs (indices 0..3) and the memory outputs (indices 4..15) are held low.
- R5: With `strap_mode` = 0, `pm_pin_n[0]` = 0 holds PCI outputs 16..20 low while the free-running PCI output (index 21) keeps running. `pm_pin_n[3]` = 0 holds AGP output 22 low while the free-running AGP output (index 23) keeps running.
- R6: A `reg_keep[i]` of 0 holds output i low, unless high impedance applies. A 1 lets it run when nothing of higher priority stops it.
- R7: With `strap_mode` = 0, memory outputs 8..11 (memory clocks 4..7) are high impedance because their pins are inputs. With `strap_mode` = 1 they behave like the other memory outputs, and `pm_pin_n` has no effect on any output.
- R8: One clock after it is sampled, `freq_sel` equals `cfg_fsel` when `cfg_fsrc` = 1, and `strap_fs` when `cfg_fsrc` = 0.
- R9: One clock after it is sampled, `spread_en` is 1 exactly when `cfg_tmode` = 2'b10. The reserved code 2'b01 acts as normal operation.
- R10: The test clock of a group with divide log L has high phases of exactly 2^L clocks. The defaults are CPU 0, AGP 1, PCI 2, REF 3, 48 MHz 1 and 24 MHz 2. An output's state changes only on the edge where its test clock goes low, so a stop never cuts a high phase short.
- R11: The memory test clocks run at the CPU rate when `strap_memsel` = 1 and at the AGP rate when it is 0.
- R12: `test_clk[i]` is high only while `out_run[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 3 | Latched frequency-select strap bits |
| strap_mode | input | 1 | Latched strap: 0 = four pins are power-management inputs |
| strap_memsel | input | 1 | Latched strap: 1 = memory clocks at CPU rate, 0 = AGP rate |
| pm_pin_n | input | 4 | Active-low pins: [0] PCI stop, [1] CPU stop, [2] power-down, [3] AGP stop |
| cfg_fsel | input | 3 | Register frequency selection |
| cfg_fsrc | input | 1 | Register: 1 = take frequency from cfg_fsel |
| cfg_tmode | input | 2 | Register: 00 normal, 01 reserved, 10 spread, 11 float |
| reg_keep | input | 27 | Per-output keep bits, 0 = hold low |
| out_run | output | 27 | Output is toggling |
| out_low | output | 27 | Output is actively held low |
| out_hiz | output | 27 | Output driver is released |
| test_clk | output | 27 | Gated divided test clock per output |
| freq_sel | output | 3 | Selected frequency code |
| spread_en | output | 1 | Spread-spectrum enable |

Output indices: CPU 0..3, memory 4..15, PCI 16..20, free PCI 21, AGP 22, free AGP 23, REF 24, 48 MHz 25, 24 MHz 26.

## Verification
`freq_sel` and `spread_en` are registered once. The bench therefore changes their inputs at a falling clock edge and samples them at the next falling edge. A gate state is due only on the next falling edge of its group's test clock, which comes at most 2^(L+1) clocks after the change (16 clocks for the slowest group). The bench therefore holds each combination of straps, pins, test mode and keep pattern for 20 clocks before it compares all 27 states. Pulse widths are counted in falling-edge samples. Only high phases that begin after a low sample are judged, so the partial phase at the start of a measurement is never counted.

// File: rtl/clkout_gate_pkg.sv
`timescale 1ns/1ps
package clkout_gate_pkg;

  typedef enum logic [2:0] {
    GRP_CPU = 3'd0,
    GRP_MEM = 3'd1,
    GRP_PCI = 3'd2,
    GRP_AGP = 3'd3,
    GRP_REF = 3'd4,
    GRP_F48 = 3'd5,
    GRP_F24 = 3'd6
  } clk_grp_e;

  localparam int NUM_GRP = 7;

  localparam logic [1:0] TM_NORMAL = 2'b00;
  localparam logic [1:0] TM_SPREAD = 2'b10;
  localparam logic [1:0] TM_FLOAT  = 2'b11;

  // Number of outputs beyond the CPU, memory and PCI ranges
  localparam int N_FIXED = 6;

  function automatic clk_grp_e grp_of(int idx, int ncpu, int nmem, int npci);
    if (idx < ncpu)                        return GRP_CPU;
    else if (idx < ncpu + nmem)            return GRP_MEM;
    else if (idx < ncpu + nmem + npci + 1) return GRP_PCI;
    else if (idx < ncpu + nmem + npci + 3) return GRP_AGP;
    else if (idx == ncpu + nmem + npci + 3) return GRP_REF;
    else if (idx == ncpu + nmem + npci + 4) return GRP_F48;
    else                                   return GRP_F24;
  endfunction

endpackage

// File: rtl/cg_phase_gen.sv
`timescale 1ns/1ps
module cg_phase_gen
  import clkout_gate_pkg::*;
#(
  parameter int CPU_LOG = 0,
  parameter int AGP_LOG = 1,
  parameter int PCI_LOG = 2,
  parameter int REF_LOG = 3,
  parameter int F48_LOG = 1,
  parameter int F24_LOG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_fast,
  output logic [NUM_GRP-1:0] upd,
  output logic [NUM_GRP-1:0] raw_nxt
);

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_LOG = max2(max2(max2(CPU_LOG, AGP_LOG), max2(PCI_LOG, REF_LOG)),
                                max2(F48_LOG, F24_LOG));
  localparam int CNT_W = MAX_LOG + 1;

  function automatic int log_of(int g);
    case (g)
      int'(GRP_CPU): return CPU_LOG;
      int'(GRP_PCI): return PCI_LOG;
      int'(GRP_AGP): return AGP_LOG;
      int'(GRP_REF): return REF_LOG;
      int'(GRP_F48): return F48_LOG;
      default:       return F24_LOG;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A group updates on the edge where its divided clock is about to fall
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == int'(GRP_MEM)) begin : g_mem
      assign upd[g]     = mem_fast ? (&cnt_q[CPU_LOG:0]) : (&cnt_q[AGP_LOG:0]);
      assign raw_nxt[g] = mem_fast ? cnt_d[CPU_LOG] : cnt_d[AGP_LOG];
    end else begin : g_fix
      localparam int LG = log_of(g);
      assign upd[g]     = &cnt_q[LG:0];
      assign raw_nxt[g] = cnt_d[LG];
    end
  end

endmodule

// File: rtl/cg_policy.sv
`timescale 1ns/1ps
module cg_policy
  import clkout_gate_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_MEM = 12,
  parameter int N_PCI = 5,
  parameter int PM_LO = 4,
  localparam int NOUT = N_CPU + N_MEM + N_PCI + N_FIXED
) (
  input  logic            strap_mode,
  input  logic [3:0]      pm_pin_n,
  input  logic [1:0]      tmode,
  input  logic [NOUT-1:0] keep,
  output logic [NOUT-1:0] d_run,
  output logic [NOUT-1:0] d_low,
  output logic [NOUT-1:0] d_hiz
);

  localparam int I_PCI0 = N_CPU + N_MEM;
  localparam int I_PCIF = I_PCI0 + N_PCI;
  localparam int I_AGP0 = I_PCIF + 1;
  localparam int I_AGPF = I_PCIF + 2;
  localparam int I_PM0  = N_CPU + PM_LO;

  logic pm_active;
  logic pwrdn;
  logic cpu_stop;
  logic pci_stop;
  logic agp_stop;
  logic float_req;

  always_comb begin
    pm_active = ~strap_mode;
    pci_stop  = pm_active & ~pm_pin_n[0];
    cpu_stop  = pm_active & ~pm_pin_n[1];
    pwrdn     = pm_active & ~pm_pin_n[2];
    agp_stop  = pm_active & ~pm_pin_n[3];
    float_req = (tmode == TM_FLOAT);
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam bit IS_CM   = (i < I_PCI0);
    localparam bit IS_PMP  = (i >= I_PM0) && (i < I_PM0 + 4);
    localparam bit IS_PCI  = (i >= I_PCI0) && (i < I_PCIF);
    localparam bit IS_AGP0 = (i == I_AGP0);
    localparam bit FLOATS  = !((i == I_AGP0) || (i == I_AGPF));

    logic hiz_w;
    logic stop_w;

    always_comb begin
      hiz_w    = (IS_PMP & pm_active) | (FLOATS & float_req);
      stop_w   = (IS_CM & cpu_stop) | (IS_PCI & pci_stop) | (IS_AGP0 & agp_stop);
      d_hiz[i] = hiz_w;
      d_run[i] = ~hiz_w & ~pwrdn & ~stop_w & keep[i];
      d_low[i] = ~hiz_w & ~d_run[i];
    end
  end

endmodule

// File: rtl/cg_gate_slice.sv
`timescale 1ns/1ps
module cg_gate_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic raw_nxt,
  input  logic d_run,
  input  logic d_low,
  input  logic d_hiz,
  output logic q_run,
  output logic q_low,
  output logic q_hiz,
  output logic q_tclk
);

  logic run_d, low_d, hiz_d, tclk_d;

  always_comb begin
    run_d  = upd ? d_run : q_run;
    low_d  = upd ? d_low : q_low;
    hiz_d  = upd ? d_hiz : q_hiz;
    tclk_d = raw_nxt & run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_run  <= 1'b0;
      q_low  <= 1'b0;
      q_hiz  <= 1'b1;
      q_tclk <= 1'b0;
    end else begin
      q_run  <= run_d;
      q_low  <= low_d;
      q_hiz  <= hiz_d;
      q_tclk <= tclk_d;
    end
  end

endmodule

// File: rtl/cg_mode_sel.sv
`timescale 1ns/1ps
module cg_mode_sel
  import clkout_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_fs,
  input  logic [2:0] cfg_fsel,
  input  logic       cfg_fsrc,
  input  logic [1:0] cfg_tmode,
  output logic [2:0] freq_sel,
  output logic       spread_en
);

  logic [2:0] fsel_d;
  logic       spread_d;

  always_comb begin
    fsel_d   = cfg_fsrc ? cfg_fsel : strap_fs;
    spread_d = (cfg_tmode == TM_SPREAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_sel  <= 3'd0;
      spread_en <= 1'b0;
    end else begin
      freq_sel  <= fsel_d;
      spread_en <= spread_d;
    end
  end

endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl
  import clkout_gate_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int N_MEM   = 12,
  parameter int N_PCI   = 5,
  parameter int PM_LO   = 4,
  parameter int CPU_LOG = 0,
  parameter int AGP_LOG = 1,
  parameter int PCI_LOG = 2,
  parameter int REF_LOG = 3,
  parameter int F48_LOG = 1,
  parameter int F24_LOG = 2,
  localparam int NOUT   = N_CPU + N_MEM + N_PCI + N_FIXED
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      strap_fs,
  input  logic            strap_mode,
  input  logic            strap_memsel,
  input  logic [3:0]      pm_pin_n,
  input  logic [2:0]      cfg_fsel,
  input  logic            cfg_fsrc,
  input  logic [1:0]      cfg_tmode,
  input  logic [NOUT-1:0] reg_keep,
  output logic [NOUT-1:0] out_run,
  output logic [NOUT-1:0] out_low,
  output logic [NOUT-1:0] out_hiz,
  output logic [NOUT-1:0] test_clk,
  output logic [2:0]      freq_sel,
  output logic            spread_en
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic [NUM_GRP-1:0] upd;
  logic [NUM_GRP-1:0] raw_nxt;
  logic [NOUT-1:0]    d_run, d_low, d_hiz;

  cg_phase_gen #(
    .CPU_LOG(CPU_LOG), .AGP_LOG(AGP_LOG), .PCI_LOG(PCI_LOG),
    .REF_LOG(REF_LOG), .F48_LOG(F48_LOG), .F24_LOG(F24_LOG)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .mem_fast(strap_memsel),
    .upd     (upd),
    .raw_nxt (raw_nxt)
  );

  cg_policy #(
    .N_CPU(N_CPU), .N_MEM(N_MEM), .N_PCI(N_PCI), .PM_LO(PM_LO)
  ) u_policy (
    .strap_mode(strap_mode),
    .pm_pin_n  (pm_pin_n),
    .tmode     (cfg_tmode),
    .keep      (reg_keep),
    .d_run     (d_run),
    .d_low     (d_low),
    .d_hiz     (d_hiz)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_slice
    localparam clk_grp_e G = grp_of(i, N_CPU, N_MEM, N_PCI);
    cg_gate_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .upd    (upd[G]),
      .raw_nxt(raw_nxt[G]),
      .d_run  (d_run[i]),
      .d_low  (d_low[i]),
      .d_hiz  (d_hiz[i]),
      .q_run  (out_run[i]),
      .q_low  (out_low[i]),
      .q_hiz  (out_hiz[i]),
      .q_tclk (test_clk[i])
    );
  end

  cg_mode_sel u_mode (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .strap_fs (strap_fs),
    .cfg_fsel (cfg_fsel),
    .cfg_fsrc (cfg_fsrc),
    .cfg_tmode(cfg_tmode),
    .freq_sel (freq_sel),
    .spread_en(spread_en)
  );

endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_chk #(
  parameter int N_CPU = 4,
  parameter int N_MEM = 12,
  parameter int NOUT  = 27
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      strap_fs,
  input logic            strap_mode,
  input logic [3:0]      pm_pin_n,
  input logic [2:0]      cfg_fsel,
  input logic            cfg_fsrc,
  input logic [1:0]      cfg_tmode,
  input logic [NOUT-1:0] reg_keep,
  input logic [NOUT-1:0] out_run,
  input logic [NOUT-1:0] out_low,
  input logic [NOUT-1:0] out_hiz,
  input logic [NOUT-1:0] test_clk,
  input logic [2:0]      freq_sel,
  input logic            spread_en
);

  localparam int N_CM = N_CPU + N_MEM;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (((out_run & out_low) | (out_run & out_hiz) | (out_low & out_hiz)) == '0) &&
    ((out_run | out_low | out_hiz) == '1));

  assert_float_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (out_run[0] && !$past(out_run[0])) |-> ($past(cfg_tmode) != 2'b11));

  assert_pwrdn_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (|(out_run & ~$past(out_run))) |-> ($past(strap_mode) || $past(pm_pin_n[2])));

  assert_cpu_stop_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (|(out_run[N_CM-1:0] & ~$past(out_run[N_CM-1:0]))) |->
      ($past(strap_mode) || $past(pm_pin_n[1])));

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ((out_run & ~$past(out_run) & ~$past(reg_keep)) == '0));

  assert_freq_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    freq_sel == ($past(cfg_fsrc) ? $past(cfg_fsel) : $past(strap_fs)));

  assert_spread_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    spread_en == ($past(cfg_tmode) == 2'b10));

  assert_full_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (((out_run ^ $past(out_run)) & test_clk) == '0));

  assert_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((test_clk & ~out_run) == '0));

endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk #(
  .N_CPU(N_CPU), .N_MEM(N_MEM), .NOUT(NOUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .strap_fs  (strap_fs),
  .strap_mode(strap_mode),
  .pm_pin_n  (pm_pin_n),
  .cfg_fsel  (cfg_fsel),
  .cfg_fsrc  (cfg_fsrc),
  .cfg_tmode (cfg_tmode),
  .reg_keep  (reg_keep),
  .out_run   (out_run),
  .out_low   (out_low),
  .out_hiz   (out_hiz),
  .test_clk  (test_clk),
  .freq_sel  (freq_sel),
  .spread_en (spread_en)
);

// File: tb/clkout_gate_ctrl_tb.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_tb;

  localparam int NOUT   = 27;
  localparam int I_MEM0 = 4;
  localparam int I_PCI0 = 16;
  localparam int I_PCIF = 21;
  localparam int I_AGP0 = 22;
  localparam int I_AGPF = 23;
  localparam int I_REF  = 24;
  localparam int I_F48  = 25;
  localparam int I_F24  = 26;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2:0]      strap_fs;
  logic            strap_mode;
  logic            strap_memsel;
  logic [3:0]      pm_pin_n;
  logic [2:0]      cfg_fsel;
  logic            cfg_fsrc;
  logic [1:0]      cfg_tmode;
  logic [NOUT-1:0] reg_keep;
  logic [NOUT-1:0] out_run, out_low, out_hiz, test_clk;
  logic [2:0]      freq_sel;
  logic            spread_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  clkout_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .strap_mode(strap_mode),
    .strap_memsel(strap_memsel), .pm_pin_n(pm_pin_n), .cfg_fsel(cfg_fsel),
    .cfg_fsrc(cfg_fsrc), .cfg_tmode(cfg_tmode), .reg_keep(reg_keep),
    .out_run(out_run), .out_low(out_low), .out_hiz(out_hiz), .test_clk(test_clk),
    .freq_sel(freq_sel), .spread_en(spread_en)
  );

  task automatic check_vec(input string req, input logic [NOUT-1:0] act,
                           input logic [NOUT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected gate states from the requirement rules
  task automatic calc_exp(input logic smode, input logic [3:0] pm, input logic [1:0] tm,
                          input logic [NOUT-1:0] kp, output logic [NOUT-1:0] er,
                          output logic [NOUT-1:0] el, output logic [NOUT-1:0] eh);
    logic act, pd, cs, ps, as_, fl;
    act = !smode;
    ps  = act && !pm[0];
    cs  = act && !pm[1];
    pd  = act && !pm[2];
    as_ = act && !pm[3];
    fl  = (tm == 2'b11);
    for (int i = 0; i < NOUT; i++) begin
      logic h, st;
      h  = (act && i >= 8 && i < 12) || (fl && i != I_AGP0 && i != I_AGPF);
      st = (i < I_PCI0 && cs) || (i >= I_PCI0 && i < I_PCIF && ps) || (i == I_AGP0 && as_);
      eh[i] = h;
      er[i] = !h && !pd && !st && kp[i];
      el[i] = !h && !er[i];
    end
  endtask

  task automatic pulse_check(input int idx, input int ncyc, input int expw,
                             input string req, input bit toggle_pci);
    int  len   = 0;
    int  seen  = 0;
    bit  valid = 1'b0;
    logic prev = test_clk[idx];
    for (int c = 0; c < ncyc; c++) begin
      if (toggle_pci && (c % 3 == 0)) pm_pin_n[0] = ~pm_pin_n[0];
      @(negedge clk);
      if (test_clk[idx]) len++;
      else begin
        if (prev && valid) begin
          seen++;
          check_int(req, len, expw);
        end
        len   = 0;
        valid = 1'b1;
      end
      prev = test_clk[idx];
    end
    if (seen == 0) check_int({req, " pulses seen"}, 0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NOUT-1:0] er, el, eh, kp;
    rst_n        = 1'b0;
    strap_fs     = 3'd5;
    strap_mode   = 1'b1;
    strap_memsel = 1'b1;
    pm_pin_n     = 4'hF;
    cfg_fsel     = 3'd2;
    cfg_fsrc     = 1'b1;
    cfg_tmode    = 2'b00;
    reg_keep     = '1;
    tick(4);
    // R1 reset state
    check_vec("R1 reset hiz", out_hiz, '1);
    check_vec("R1 reset run", out_run, '0);
    check_vec("R1 reset low", out_low, '0);
    check_vec("R1 reset test_clk", test_clk, '0);
    check_int("R8 reset freq_sel", int'(freq_sel), 0);
    check_int("R9 reset spread_en", int'(spread_en), 0);
    rst_n = 1'b1;
    tick(24);

    // Sweep: straps, pins, test mode and keep patterns (R2..R7, R12)
    for (int sm = 0; sm < 2; sm++) begin
      for (int pm = 0; pm < 16; pm++) begin
        for (int tm = 0; tm < 4; tm++) begin
          for (int kpat = 0; kpat < 3; kpat++) begin
            for (int i = 0; i < NOUT; i++)
              kp[i] = (kpat == 0) ? 1'b1 : (kpat == 1) ? 1'b0 : 1'(i % 2);
            strap_mode = 1'(sm);
            pm_pin_n   = 4'(pm);
            cfg_tmode  = 2'(tm);
            reg_keep   = kp;
            tick(20);
            calc_exp(1'(sm), 4'(pm), 2'(tm), kp, er, el, eh);
            check_vec("R2/R3/R4/R5/R6/R7 run", out_run, er);
            check_vec("R2/R3/R4/R5/R6/R7 low", out_low, el);
            check_vec("R2/R7 hiz", out_hiz, eh);
            check_vec("R12 test_clk gated", test_clk & ~er, '0);
          end
        end
      end
    end

    // R8 frequency source, exhaustive
    for (int src = 0; src < 2; src++)
      for (int sel = 0; sel < 8; sel++)
        for (int fs = 0; fs < 8; fs++) begin
          cfg_fsrc = 1'(src);
          cfg_fsel = 3'(sel);
          strap_fs = 3'(fs);
          tick(1);
          check_int("R8 freq_sel", int'(freq_sel), (src != 0) ? sel : fs);
        end

    // R9 spread enable per code
    for (int tm = 0; tm < 4; tm++) begin
      cfg_tmode = 2'(tm);
      tick(1);
      check_int("R9 spread_en", int'(spread_en), (tm == 2) ? 1 : 0);
    end

    // R10 / R11 pulse widths, all outputs running
    cfg_tmode    = 2'b00;
    strap_mode   = 1'b1;
    pm_pin_n     = 4'hF;
    reg_keep     = '1;
    strap_memsel = 1'b1;
    tick(20);
    pulse_check(0,      60, 1, "R10 cpu width", 1'b0);
    pulse_check(I_MEM0, 60, 1, "R11 mem at cpu rate", 1'b0);
    pulse_check(I_AGP0, 60, 2, "R10 agp width", 1'b0);
    pulse_check(I_PCI0, 60, 4, "R10 pci width", 1'b0);
    pulse_check(I_REF,  80, 8, "R10 ref width", 1'b0);
    pulse_check(I_F48,  60, 2, "R10 f48 width", 1'b0);
    pulse_check(I_F24,  60, 4, "R10 f24 width", 1'b0);
    strap_memsel = 1'b0;
    tick(20);
    pulse_check(I_MEM0, 60, 2, "R11 mem at agp rate", 1'b0);

    // R10 / R5 stop toggling never shortens a PCI pulse, free PCI keeps running
    strap_mode = 1'b0;
    tick(20);
    pulse_check(I_PCI0, 120, 4, "R10 pci under stop toggling", 1'b1);
    pulse_check(I_PCIF, 120, 4, "R5 free pci under stop toggling", 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule